// File: doc/BRIEF.md
# Fermat-Modulus Transform Butterfly

This block is the radix-2 butterfly of a 64-point number-theoretic transform over the prime p = 2^32 + 1. Operands are 33-bit residues. The root of unity is 2, so every twiddle factor is a power of two. Each twiddle product is therefore a left shift followed by a folding reduction that uses the identity 2^32 ≡ −1 (mod p). The block has no hardware multipliers.

The same unit serves both forward and inverse transforms. The lower operand is always scaled by 2^e_down. The upper operand is scaled only when the final-inverse flag is set. In that stage the caller supplies an exponent that already contains the 1/64 scaling factor. Because 2^−6 ≡ 2^58, this removes a separate normalisation pass. In all other stages the upper operand passes through unscaled. The unit then emits the sum and the difference of the two legs, each fully reduced.

Operations enter and leave through valid/ready streams. A beat is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. A result is delivered on an edge where `out_valid` and `out_ready` are both high. The pipeline advances as one unit whenever the output slot is empty or is being drained. `in_ready` is low exactly when a result is waiting and `out_ready` is low. While it waits, that result holds steady. A producer must hold its beat until it is accepted.

Top module: `fermat_butterfly`

## Requirements
- R1: While reset (`rst_n` low) is applied, `out_valid` is low, and it stays low until a beat has been accepted.
- R2: The lower leg value is b = `in_down` · 2^`in_exp_down` mod p, for any exponent 0..63.
- R3: When `in_inv_last` is 0, the upper leg value is a = `in_up`, and `in_exp_up` has no effect on either output.
- R4: When `in_inv_last` is 1, the upper leg value is a = `in_up` · 2^`in_exp_up` mod p.
- R5: `out_up` equals (a + b) mod p and is always less than p, including when both legs equal p − 1.
- R6: `out_down` equals (a − b) mod p and is always less than p, so a negative difference wraps by adding p.
- R7: Exponents of 32 and above act as negation times 2^(e−32), and 2^e · 2^(64−e) ≡ 1. For example, scaling 64 by 2^58 yields 1.
- R8: With `out_ready` held high, a beat accepted on one edge appears on `out_valid` after exactly 8 rising edges.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid`, `out_up` and `out_down` hold their values.
- R10: Every accepted beat produces exactly one result, in acceptance order, under any pattern of input gaps and output stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can accept a beat this cycle |
| in_up | input | 33 | Upper operand, residue below p |
| in_down | input | 33 | Lower operand, residue below p |
| in_exp_up | input | 6 | Upper twiddle exponent, used only in the final inverse stage |
| in_exp_down | input | 6 | Lower twiddle exponent |
| in_inv_last | input | 1 | 1 = final inverse stage: scale the upper leg |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_up | output | 33 | (a + b) mod p |
| out_down | output | 33 | (a − b) mod p |

## Verification
The hardest case to reach is a pipeline that is full while its output is stalled, so that a stalled result, a held input beat and in-flight bubbles all coexist. The bench creates this with a long random stream. In that stream the input valid goes on and off at random and `out_ready` drops about one cycle in four. Every result is compared in order against a model built from plain modular arithmetic. Directed vectors reach the reduction edges: the all-(p−1) sum, a negative difference, the negation band of the exponent, and the inverse-scaling identity.

// File: rtl/fbfly_pkg.sv
package fbfly_pkg;
  localparam int unsigned FB_HALF_W = 32;  // p = 2^FB_HALF_W + 1
  localparam int unsigned FB_DEPTH  = 8;   // pipeline registers, input to output
endpackage

// File: rtl/fbfly_vpipe.sv
module fbfly_vpipe #(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic vin,
  output logic vout
);
  logic [DEPTH-1:0] vsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vsr <= '0;
    else if (adv) vsr <= {vsr[DEPTH-2:0], vin};
  end

  assign vout = vsr[DEPTH-1];
endmodule

// File: rtl/fbfly_twiddle.sv
// Four-register multiply by 2^e mod (2^HALF_W + 1): shift, fold, fix sign, negate.
module fbfly_twiddle #(
  parameter int unsigned HALF_W = 32
) (
  input  logic                            clk,
  input  logic                            adv,
  input  logic [HALF_W:0]                 x,
  input  logic [$clog2(2*HALF_W)-1:0]     e,
  output logic [HALF_W:0]                 y
);
  localparam int unsigned RES_W  = HALF_W + 1;
  localparam int unsigned EXP_W  = $clog2(2*HALF_W);
  localparam int unsigned SH_W   = EXP_W - 1;
  localparam int unsigned PROD_W = 2 * RES_W;
  localparam int unsigned ACC_W  = HALF_W + 3;
  localparam logic [RES_W-1:0] P = {1'b1, {(HALF_W-1){1'b0}}, 1'b1};

  logic [PROD_W-1:0]       prod_q;
  logic                    neg_a, neg_b, neg_c;
  logic signed [ACC_W-1:0] fold_d, fold_q;
  logic [RES_W-1:0]        fix_d, fix_q, out_d, out_q;

  // The shift uses the low exponent bits; the top bit means one factor of 2^HALF_W = -1.
  always_ff @(posedge clk) begin
    if (adv) begin
      prod_q <= PROD_W'(x) << e[SH_W-1:0];
      neg_a  <= e[EXP_W-1];
    end
  end

  always_comb begin
    fold_d = $signed(ACC_W'(prod_q[HALF_W-1:0]))
           + $signed(ACC_W'(prod_q[PROD_W-1:2*HALF_W]))
           - $signed(ACC_W'(prod_q[2*HALF_W-1:HALF_W]));
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      fold_q <= fold_d;
      neg_b  <= neg_a;
    end
  end

  always_comb begin
    if (fold_q < 0) fix_d = RES_W'(fold_q + $signed(ACC_W'(P)));
    else            fix_d = RES_W'(fold_q);
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      fix_q <= fix_d;
      neg_c <= neg_b;
    end
  end

  always_comb begin
    if (neg_c && (fix_q != '0)) out_d = P - fix_q;
    else                        out_d = fix_q;
  end

  always_ff @(posedge clk) begin
    if (adv) out_q <= out_d;
  end

  assign y = out_q;
endmodule

// File: rtl/fbfly_addsub.sv
// Two-register modular sum and difference.
module fbfly_addsub #(
  parameter int unsigned HALF_W = 32
) (
  input  logic            clk,
  input  logic            adv,
  input  logic [HALF_W:0] a,
  input  logic [HALF_W:0] b,
  output logic [HALF_W:0] s,
  output logic [HALF_W:0] d
);
  localparam int unsigned RES_W = HALF_W + 1;
  localparam logic [RES_W:0] P_EXT = {2'b01, {(HALF_W-1){1'b0}}, 1'b1};

  logic [RES_W:0]   sum_q, dif_q;
  logic             borrow_q;
  logic [RES_W-1:0] s_d, d_d, s_q, d_q;

  always_ff @(posedge clk) begin
    if (adv) begin
      sum_q    <= {1'b0, a} + {1'b0, b};
      dif_q    <= {1'b0, a} - {1'b0, b};
      borrow_q <= (a < b);
    end
  end

  always_comb begin
    if (sum_q >= P_EXT) s_d = RES_W'(sum_q - P_EXT);
    else                s_d = RES_W'(sum_q);
    if (borrow_q)       d_d = RES_W'(dif_q + P_EXT);
    else                d_d = RES_W'(dif_q);
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s_q <= s_d;
      d_q <= d_d;
    end
  end

  assign s = s_q;
  assign d = d_q;
endmodule

// File: rtl/fermat_butterfly.sv
module fermat_butterfly
  import fbfly_pkg::*;
#(
  parameter int unsigned HALF_W = FB_HALF_W,
  parameter int unsigned EXP_W  = $clog2(2*HALF_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HALF_W:0]   in_up,
  input  logic [HALF_W:0]   in_down,
  input  logic [EXP_W-1:0]  in_exp_up,
  input  logic [EXP_W-1:0]  in_exp_down,
  input  logic              in_inv_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HALF_W:0]   out_up,
  output logic [HALF_W:0]   out_down
);
  localparam int unsigned RES_W = HALF_W + 1;

  logic             adv;
  logic [RES_W-1:0] leg_x [2];
  logic [EXP_W-1:0] leg_e [2];
  logic [RES_W-1:0] leg_y [2];
  logic [RES_W-1:0] sum_w, dif_w;
  logic [RES_W-1:0] up_q, down_q;

  // Whole pipeline moves together unless a finished result is stalled.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Register 1: capture. Exponent of the upper leg is zeroed outside the final inverse stage.
  always_ff @(posedge clk) begin
    if (adv) begin
      leg_x[0] <= in_up;
      leg_e[0] <= in_inv_last ? in_exp_up : '0;
      leg_x[1] <= in_down;
      leg_e[1] <= in_exp_down;
    end
  end

  // Registers 2..5: one twiddle unit per leg.
  for (genvar g = 0; g < 2; g++) begin : g_leg
    fbfly_twiddle #(.HALF_W(HALF_W)) u_twd (
      .clk (clk),
      .adv (adv),
      .x   (leg_x[g]),
      .e   (leg_e[g]),
      .y   (leg_y[g])
    );
  end

  // Registers 6..7: modular sum and difference.
  fbfly_addsub #(.HALF_W(HALF_W)) u_as (
    .clk (clk),
    .adv (adv),
    .a   (leg_y[0]),
    .b   (leg_y[1]),
    .s   (sum_w),
    .d   (dif_w)
  );

  // Register 8: output.
  always_ff @(posedge clk) begin
    if (adv) begin
      up_q   <= sum_w;
      down_q <= dif_w;
    end
  end

  fbfly_vpipe #(.DEPTH(FB_DEPTH)) u_vp (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .vin   (in_valid),
    .vout  (out_valid)
  );

  assign out_up   = up_q;
  assign out_down = down_q;
endmodule

// File: rtl/fermat_butterfly_chk.sv
module fermat_butterfly_chk #(
  parameter int unsigned HALF_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [HALF_W:0] out_up,
  input logic [HALF_W:0] out_down
);
  localparam logic [HALF_W:0] P = {1'b1, {(HALF_W-1){1'b0}}, 1'b1};

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R1

  AST_SUM_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_up < P)); // R5

  AST_DIF_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_down < P)); // R6

  AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_up) && $stable(out_down))); // R9
endmodule

bind fermat_butterfly fermat_butterfly_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_up    (out_up),
  .out_down  (out_down)
);

// File: tb/test_fermat_butterfly.sv
module test_fermat_butterfly;
  localparam logic [32:0] P  = 33'h1_0000_0001;
  localparam int          NV = 8;
  localparam int          NR = 300;

  // Directed vectors: up, down, exp_up, exp_down, inv_last -> expected sum, diff
  localparam logic [32:0] V_UP  [NV] = '{33'd5, 33'd1, 33'd0, 33'd64, 33'd7, 33'h1_0000_0000, 33'd3, 33'd0};
  localparam logic [32:0] V_DN  [NV] = '{33'd3, 33'd1, 33'd1, 33'd0, 33'd2, 33'h1_0000_0000, 33'd5, 33'h1_0000_0000};
  localparam logic [5:0]  V_EU  [NV] = '{6'd0, 6'd0, 6'd0, 6'd58, 6'd63, 6'd0, 6'd1, 6'd0};
  localparam logic [5:0]  V_ED  [NV] = '{6'd0, 6'd1, 6'd32, 6'd0, 6'd0, 6'd0, 6'd0, 6'd63};
  localparam logic        V_INV [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [32:0] V_SUM [NV] = '{33'd8, 33'd3, 33'h1_0000_0000, 33'd1, 33'd9, 33'hFFFF_FFFF, 33'd11, 33'd2147483648};
  localparam logic [32:0] V_DIF [NV] = '{33'd2, 33'h1_0000_0000, 33'd1, 33'd1, 33'd5, 33'd0, 33'd1, 33'd2147483649};
  localparam string       V_REQ [NV] = '{"R5", "R6", "R7", "R4", "R3", "R5", "R4", "R2"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [32:0] in_up = '0, in_down = '0;
  logic [5:0]  in_exp_up = '0, in_exp_down = '0;
  logic        in_inv_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [32:0] out_up, out_down;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [32:0] r_up [NR], r_dn [NR], e_sum [NR], e_dif [NR];
  logic [5:0]  r_eu [NR], r_ed [NR];
  logic        r_inv [NR];

  always #4 clk = ~clk;

  fermat_butterfly i_fermat_butterfly (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_up(in_up), .in_down(in_down), .in_exp_up(in_exp_up), .in_exp_down(in_exp_down),
    .in_inv_last(in_inv_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_up(out_up), .out_down(out_down)
  );

  function automatic logic [32:0] mulpow(logic [32:0] x, int e);
    logic [127:0] acc;
    acc = 128'(x);
    for (int i = 0; i < e; i++) acc = (acc * 2) % 128'(P);
    return acc[32:0];
  endfunction

  task automatic check(string req, string what, logic [32:0] act, logic [32:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int ri, si, lat;
    bit in_fire, out_fire, held;
    logic [32:0] h_up, h_dn;
    logic [127:0] a, b;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", 33'(out_valid), 33'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "out_valid idle after reset", 33'(out_valid), 33'd0);

    // Directed table, one beat at a time, latency measured (R8)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      in_valid = 1'b1; in_up = V_UP[v]; in_down = V_DN[v];
      in_exp_up = V_EU[v]; in_exp_down = V_ED[v]; in_inv_last = V_INV[v];
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      lat = 1;
      while (!out_valid && lat < 20) begin
        @(negedge clk);
        lat++;
      end
      check("R8", "latency", 33'(lat), 33'd8);
      check(V_REQ[v], "sum", out_up, V_SUM[v]);
      check(V_REQ[v], "diff", out_down, V_DIF[v]);
    end

    // Random stream with gaps and stalls against a modular model (R2..R7, R9, R10)
    for (int k = 0; k < NR; k++) begin
      r_up[k]  = ($urandom % 16 == 0) ? P - 33'd1 : 33'($urandom);
      r_dn[k]  = ($urandom % 16 == 0) ? P - 33'd1 : 33'($urandom);
      r_eu[k]  = 6'($urandom);
      r_ed[k]  = 6'($urandom);
      r_inv[k] = 1'($urandom);
      a = r_inv[k] ? 128'(mulpow(r_up[k], int'(r_eu[k]))) : 128'(r_up[k]);
      b = 128'(mulpow(r_dn[k], int'(r_ed[k])));
      e_sum[k] = 33'((a + b) % 128'(P));
      e_dif[k] = 33'((a + 128'(P) - b) % 128'(P));
    end
    ri = 0; si = 0; in_fire = 1'b0; held = 1'b0; h_up = '0; h_dn = '0;
    while (ri < NR) begin
      @(negedge clk);
      if (in_fire) si++;
      if (!in_valid || in_fire) begin
        in_valid = (si < NR) && ($urandom % 3 != 0);
        if (si < NR) begin
          in_up = r_up[si]; in_down = r_dn[si];
          in_exp_up = r_eu[si]; in_exp_down = r_ed[si]; in_inv_last = r_inv[si];
        end
      end
      out_ready = ($urandom % 4 != 0);
      #1;
      if (held) begin
        check("R9", "stalled valid", 33'(out_valid), 33'd1);
        check("R9", "stalled sum held", out_up, h_up);
        check("R9", "stalled diff held", out_down, h_dn);
      end
      if (out_valid && !out_ready) check("R9", "in_ready during stall", 33'(in_ready), 33'd0);
      held = out_valid && !out_ready;
      h_up = out_up; h_dn = out_down;
      in_fire  = in_valid && in_ready;
      out_fire = out_valid && out_ready;
      if (out_fire) begin
        if (ri >= si + (in_fire ? 1 : 0) + 1) begin
          n_chk++; n_fail++;
          $display("FAIL R10 extra result: actual %0d expected %0d", ri + 1, si);
        end
        check("R10", "stream sum (R5 R2 R4)", out_up, e_sum[ri]);
        check("R10", "stream diff (R6 R3 R7)", out_down, e_dif[ri]);
        ri++;
      end
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (12) @(negedge clk);
    check("R10", "no leftover result", 33'(out_valid), 33'd0);

    // R3 directed: exp_up has no effect outside the final inverse stage
    @(negedge clk);
    in_valid = 1'b1; in_up = 33'd1000; in_down = 33'd0;
    in_exp_up = 6'd40; in_exp_down = 6'd0; in_inv_last = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (7) @(negedge clk);
    check("R3", "upper unscaled sum", out_up, 33'd1000);
    check("R3", "upper unscaled diff", out_down, 33'd1000);

    // R1 again: reset mid-flight clears pending result
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1", "flushed by reset", 33'(out_valid), 33'd0);

    finish_run();
  end
endmodule